// File: doc/BRIEF.md
# Per-Branch History Direction Predictor

This block guesses whether a conditional branch will be taken, using only the recent outcomes of that same branch. The lookup has two steps. Six bits of the branch address pick one register from a small table of per-branch histories. That history value then serves as the address of a large table of 2-bit saturating counters. The upper bit of the chosen counter is the prediction. The predict port is purely combinational, so a fetch stage can present an address and read the direction in the same cycle.

Resolved branches come back through the update port. It captures the address and outcome on a clock edge. On the next edge it does two writes. It trains the counter that the branch's history pointed at before this outcome, and it shifts the outcome into that branch's history. The history length is the parameter `HIST_W`. A full-size build uses 14 bits, which gives 16384 counters. The default is 10 bits, which keeps the counter table at 1024 entries.

After reset the block sweeps both tables to their start values. The controller has two states. `ST_CLEAR` is entered from reset. It writes one counter address per cycle (counter = 1) and one history address per cycle (history = 0). It moves to `ST_RUN` on the cycle its sweep pointer reaches the last address. `ST_RUN` has no exit other than reset. The output `ready` is high only in `ST_RUN`.

Top module: `lhist_bp_top`

## Requirements
- R1: While `ready` is low (state `ST_CLEAR`), `pred_taken` is 0 for every `pred_pc`.
- R2: After `rst_n` is released, `ready` rises on the edge numbered max(2^HIST_W, 2^IDX_W), counting edges from the release; 1024 with the defaults. Once high, it stays high until reset.
- R3: When the sweep completes, every history holds 0 and every counter holds 1, so every `pred_pc` predicts not taken.
- R4: `pred_taken` is bit 1 of the counter addressed by the history of the entry that `pred_pc` selects. Counter values 2 and 3 mean taken. The output follows `pred_pc` in the same cycle.
- R5: The history entry is selected by `pred_pc[7:2]` and `upd_pc[7:2]`. All other address bits have no effect.
- R6: An update presented with `upd_valid` high is captured at one clock edge and written at the next. The prediction for that branch changes only after the second edge.
- R7: An update trains the counter addressed by the branch's history before the update. On taken the counter adds 1 and stops at 3. On not taken it subtracts 1 and stops at 0.
- R8: On update, the branch's history shifts left by one. The outcome (1 = taken, 0 = not taken) enters bit 0, and the oldest bit is dropped.
- R9: Updates presented while `ready` is low, and inputs presented while `upd_valid` is low, change no table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; starts the table sweep |
| pred_pc | input | PC_W | Address of the branch to predict |
| pred_taken | output | 1 | 1 = predicted taken |
| upd_valid | input | 1 | Update request strobe |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |
| ready | output | 1 | High once the start-up sweep is finished |

## Verification
An always-taken run on one branch separates a design that addresses counters by history from one that addresses them by branch address. The prediction must stay not taken through the first HIST_W outcomes and turn taken only on the next one, because each step reaches a fresh counter. An alternating run and a long not-taken run compared against a reference model show whether a design trains at the old history or the new one, and whether the counters wrap instead of saturating. Address variants that differ only outside bits 7:2, updates fed in during the sweep, and a single update observed one edge early separately expose a wrong index slice, a missing gate while clearing, and wrong write latency.

// File: rtl/lhist_bp_pkg.sv
package lhist_bp_pkg;

    typedef enum logic [0:0] {
        ST_CLEAR = 1'b0,
        ST_RUN   = 1'b1
    } bp_state_e;

    localparam logic [1:0] CTR_INIT = 2'd1;

    // Saturating 2-bit counter step.
    function automatic logic [1:0] ctr_step(input logic [1:0] cur, input logic taken);
        logic [1:0] nxt;
        if (taken) nxt = (cur == 2'd3) ? 2'd3 : cur + 2'd1;
        else       nxt = (cur == 2'd0) ? 2'd0 : cur - 2'd1;
        return nxt;
    endfunction

endpackage

// File: rtl/lhist_bp_table.sv
module lhist_bp_table #(
    parameter int               DATA_W = 2,
    parameter int               ADDR_W = 6,
    parameter logic [DATA_W-1:0] INIT  = '0
) (
    input  logic              clk,
    input  logic              clr_en,
    input  logic [ADDR_W-1:0] clr_addr,
    input  logic [ADDR_W-1:0] rd_a_addr,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [ADDR_W-1:0] rd_b_addr,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Sweep writes take priority; the controller never overlaps them.
    always_ff @(posedge clk) begin
        if (clr_en)     mem[clr_addr] <= INIT;
        else if (wr_en) mem[wr_addr]  <= wr_data;
    end

    assign rd_a_data = mem[rd_a_addr];
    assign rd_b_data = mem[rd_b_addr];

endmodule

// File: rtl/lhist_bp_upd_stage.sv
module lhist_bp_upd_stage #(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic             in_valid,
    input  logic [IDX_W-1:0] in_idx,
    input  logic             in_taken,
    output logic             out_valid,
    output logic [IDX_W-1:0] out_idx,
    output logic             out_taken
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_idx   <= '0;
            out_taken <= 1'b0;
        end else begin
            out_valid <= in_valid && accept;
            out_idx   <= in_idx;
            out_taken <= in_taken;
        end
    end

endmodule

// File: rtl/lhist_bp_top.sv
module lhist_bp_top
    import lhist_bp_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int IDX_LSB = 2,
    parameter int IDX_W   = 6,
    parameter int HIST_W  = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] pred_pc,
    output logic            pred_taken,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken,
    output logic            ready
);
    localparam int PTR_W   = (HIST_W > IDX_W) ? HIST_W : IDX_W;
    localparam int CLR_CNT = 1 << PTR_W;

    bp_state_e          state_q, state_d;
    logic [PTR_W-1:0]   clr_ptr_q;
    logic               clr_en, run;

    // Address bits outside the index field are deliberately unused.
    logic unused_pc_bits;
    assign unused_pc_bits = ^{pred_pc, upd_pc};

    // State register and sweep pointer.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_CLEAR;
            clr_ptr_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_CLEAR) clr_ptr_q <= clr_ptr_q + PTR_W'(1);
        end
    end

    // Next state.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CLEAR: if (clr_ptr_q == PTR_W'(CLR_CNT - 1)) state_d = ST_RUN;
            ST_RUN:   state_d = ST_RUN;
        endcase
    end

    // State outputs.
    always_comb begin
        clr_en = 1'b0;
        run    = 1'b0;
        unique case (state_q)
            ST_CLEAR: clr_en = 1'b1;
            ST_RUN:   run    = 1'b1;
        endcase
    end

    assign ready = run;

    // Update capture stage.
    logic             stg_valid, stg_taken;
    logic [IDX_W-1:0] stg_idx;

    lhist_bp_upd_stage #(.IDX_W(IDX_W)) upd_stage_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (run),
        .in_valid  (upd_valid),
        .in_idx    (upd_pc[IDX_LSB +: IDX_W]),
        .in_taken  (upd_taken),
        .out_valid (stg_valid),
        .out_idx   (stg_idx),
        .out_taken (stg_taken)
    );

    // Update path values.
    logic              wr_en;
    logic [HIST_W-1:0] pred_hist, old_hist, new_hist;
    logic [1:0]        pred_ctr, old_ctr, new_ctr;

    assign wr_en    = stg_valid && run;
    assign new_hist = {old_hist[HIST_W-2:0], stg_taken};
    assign new_ctr  = ctr_step(old_ctr, stg_taken);

    // First level: per-branch histories.
    lhist_bp_table #(.DATA_W(HIST_W), .ADDR_W(IDX_W), .INIT('0)) hist_tbl_i (
        .clk       (clk),
        .clr_en    (clr_en),
        .clr_addr  (clr_ptr_q[IDX_W-1:0]),
        .rd_a_addr (pred_pc[IDX_LSB +: IDX_W]),
        .rd_a_data (pred_hist),
        .rd_b_addr (stg_idx),
        .rd_b_data (old_hist),
        .wr_en     (wr_en),
        .wr_addr   (stg_idx),
        .wr_data   (new_hist)
    );

    // Second level: counters addressed by history.
    lhist_bp_table #(.DATA_W(2), .ADDR_W(HIST_W), .INIT(CTR_INIT)) ctr_tbl_i (
        .clk       (clk),
        .clr_en    (clr_en),
        .clr_addr  (clr_ptr_q[HIST_W-1:0]),
        .rd_a_addr (pred_hist),
        .rd_a_data (pred_ctr),
        .rd_b_addr (old_hist),
        .rd_b_data (old_ctr),
        .wr_en     (wr_en),
        .wr_addr   (old_hist),
        .wr_data   (new_ctr)
    );

    assign pred_taken = run && pred_ctr[1];

endmodule

// File: rtl/lhist_bp_chk.sv
module lhist_bp_chk #(
    parameter int HIST_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ready,
    input logic              pred_taken,
    input logic              upd_valid,
    input logic              wr_en,
    input logic              wr_taken,
    input logic [1:0]        old_ctr,
    input logic [1:0]        new_ctr,
    input logic [HIST_W-1:0] old_hist,
    input logic [HIST_W-1:0] new_hist
);
    // R1
    a_r1_quiet_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> !pred_taken);

    // R2
    a_r2_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);

    // R6
    a_r6_write_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && ready) |=> wr_en);

    // R9
    a_r9_no_write_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> !wr_en);

    // R7
    a_r7_ctr_up: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_taken) |-> (new_ctr == ((old_ctr == 2'd3) ? 2'd3 : old_ctr + 2'd1)));

    a_r7_ctr_down: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_taken) |-> (new_ctr == ((old_ctr == 2'd0) ? 2'd0 : old_ctr - 2'd1)));

    // R8
    a_r8_hist_shift: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (new_hist[0] == wr_taken && new_hist[HIST_W-1:1] == old_hist[HIST_W-2:0]));

endmodule

bind lhist_bp_top lhist_bp_chk #(.HIST_W(HIST_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ready      (ready),
    .pred_taken (pred_taken),
    .upd_valid  (upd_valid),
    .wr_en      (wr_en),
    .wr_taken   (stg_taken),
    .old_ctr    (old_ctr),
    .new_ctr    (new_ctr),
    .old_hist   (old_hist),
    .new_hist   (new_hist)
);

// File: tb/lhist_bp_top_tb_top.sv
module lhist_bp_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HW         = 10;
    localparam int IW         = 6;
    localparam int NENT       = 1 << IW;
    localparam int NCTR       = 1 << HW;
    localparam int CLR_CYC    = (NCTR > NENT) ? NCTR : NENT;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pred_pc = '0;
    logic        pred_taken;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_pc = '0;
    logic        upd_taken = 1'b0;
    logic        ready;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // Reference state, built from the requirements.
    int mh [NENT];
    int mc [NCTR];

    always #(CLK_PERIOD/2) clk = ~clk;

    lhist_bp_top #(.PC_W(32), .IDX_LSB(2), .IDX_W(IW), .HIST_W(HW)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .pred_pc    (pred_pc),
        .pred_taken (pred_taken),
        .upd_valid  (upd_valid),
        .upd_pc     (upd_pc),
        .upd_taken  (upd_taken),
        .ready      (ready)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int idx_of(input logic [31:0] pc);
        return int'(pc[7:2]);
    endfunction

    function automatic int mdl_pred(input logic [31:0] pc);
        return (mc[mh[idx_of(pc)]] >= 2) ? 1 : 0;
    endfunction

    task automatic mdl_upd(input logic [31:0] pc, input logic t);
        int e = idx_of(pc);
        int h = mh[e];
        if (t) mc[h] = (mc[h] == 3) ? 3 : mc[h] + 1;
        else   mc[h] = (mc[h] == 0) ? 0 : mc[h] - 1;
        mh[e] = ((h << 1) | int'(t)) & (NCTR - 1);
    endtask

    task automatic mdl_reset();
        for (int i = 0; i < NENT; i++) mh[i] = 0;
        for (int i = 0; i < NCTR; i++) mc[i] = 1;
    endtask

    task automatic peek(input logic [31:0] pc, output int r);
        @(negedge clk);
        pred_pc = pc;
        #1;
        r = int'(pred_taken);
    endtask

    // One update; returns once both tables have been written.
    task automatic drive_upd(input logic [31:0] pc, input logic t);
        @(negedge clk);
        upd_valid = 1'b1;
        upd_pc    = pc;
        upd_taken = t;
        mdl_upd(pc, t);
        @(negedge clk);
        upd_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic compare_all(input string req, input logic [23:0] hi, input logic [1:0] lo);
        int r;
        for (int i = 0; i < NENT; i++) begin
            logic [31:0] pc = {hi, i[5:0], lo};
            peek(pc, r);
            chk(req, r, mdl_pred(pc));
        end
    endtask

    // R1, R2, R3, R9: reset sweep, with updates offered while clearing.
    task automatic t_reset_sweep();
        int k = 0;
        mdl_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        while (k < 5000) begin
            @(negedge clk);
            k++;
            if (k <= 100) begin
                upd_valid = 1'b1; upd_pc = 32'h0000_0040; upd_taken = 1'b1;
            end else begin
                upd_valid = 1'b0;
            end
            pred_pc = 32'h0000_0040;
            #1;
            if (k == 1) begin
                chk("R1 ready low", int'(ready), 0);
                chk("R1 pred low", int'(pred_taken), 0);
            end
            if (ready) break;
        end
        upd_valid = 1'b0;
        chk("R2 sweep length", k, CLR_CYC);
        repeat (3) @(negedge clk);
        chk("R2 ready sticky", int'(ready), 1);
        compare_all("R3 all not taken", 24'h0, 2'b00);
    endtask

    // R9: updates during sweep left no trace; idle inputs are ignored.
    task automatic t_ignore();
        int r;
        drive_upd(32'h0000_0040, 1'b1);
        peek(32'h0000_0040, r);
        chk("R9 no update while clearing", r, 0);
        @(negedge clk);
        upd_valid = 1'b0; upd_pc = 32'h1234_5678; upd_taken = 1'b1;
        repeat (6) @(negedge clk);
        upd_pc = 32'h0000_0014; upd_taken = 1'b0;
        repeat (6) @(negedge clk);
        compare_all("R9 valid low ignored", 24'h0, 2'b00);
    endtask

    // R4: always-taken branch steps through fresh counters.
    task automatic t_chain();
        int r;
        for (int n = 1; n <= HW + 1; n++) begin
            drive_upd(32'h0000_0014, 1'b1);
            peek(32'h0000_0014, r);
            chk("R4 chained lookup model", r, mdl_pred(32'h0000_0014));
            if (n == HW)     chk("R4 all-ones history unseen", r, 0);
            if (n == HW + 1) chk("R4 trained counter taken", r, 1);
        end
    endtask

    // R6: prediction changes only after the write edge.
    task automatic t_latency();
        @(negedge clk);
        upd_valid = 1'b1; upd_pc = 32'h0000_0014; upd_taken = 1'b0;
        mdl_upd(32'h0000_0014, 1'b0);
        @(negedge clk);
        upd_valid = 1'b0;
        pred_pc = 32'h0000_0014;
        #1;
        chk("R6 unchanged after capture edge", int'(pred_taken), 1);
        @(negedge clk);
        #1;
        chk("R6 changed after write edge", int'(pred_taken), 0);
    endtask

    // R5: bits outside [7:2] do not alter the entry.
    task automatic t_alias();
        compare_all("R5 upper bits ignored", 24'hABCDEF, 2'b11);
        drive_upd(32'hFFFF_FF00 | (32'd12 << 2) | 32'd1, 1'b1);
        drive_upd(32'h0F00_0000 | (32'd12 << 2) | 32'd2, 1'b1);
        compare_all("R5 aliased updates", 24'h0, 2'b00);
        compare_all("R5 aliased lookups", 24'h5A5A5A, 2'b01);
    endtask

    // R7: floor and ceiling of the counters.
    task automatic t_saturate();
        int r;
        for (int n = 0; n < 2 * HW + 3; n++) drive_upd(32'h0000_00A0, 1'b0);
        peek(32'h0000_00A0, r);
        chk("R7 floor at zero", r, 0);
        chk("R7 floor model", r, mdl_pred(32'h0000_00A0));
        for (int n = 0; n < 3 * HW; n++) drive_upd(32'h0000_0014, 1'b1);
        drive_upd(32'h0000_0014, 1'b0);
        for (int n = 0; n < HW; n++) drive_upd(32'h0000_0014, 1'b1);
        peek(32'h0000_0014, r);
        chk("R7 ceiling at three", r, 1);
        compare_all("R7 saturation model", 24'h0, 2'b00);
    endtask

    // R8: alternating branch learns its own pattern.
    task automatic t_alternate();
        int r;
        for (int n = 0; n < 4 * HW; n++) begin
            drive_upd(32'h0000_0084, (n % 2) == 0);
            peek(32'h0000_0084, r);
            chk("R8 alternating model", r, mdl_pred(32'h0000_0084));
        end
        // Last outcome was not taken; the pattern predicts taken next.
        chk("R8 alternating learned", r, 1);
        compare_all("R8 history state", 24'h0, 2'b00);
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        t_reset_sweep();
        t_ignore();
        t_chain();
        t_latency();
        t_alias();
        t_saturate();
        t_alternate();
        done = 1'b1;
        report();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            report();
        end
    end

endmodule